// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block takes serial words from an external master that drives both a serial clock and a serial data line. Both lines pass through a two-flop synchronizer into the system clock domain. The block samples the data bit on each falling edge of the effective clock, least significant bit first, and shifts it into a shift register. The effective clock and the effective data are the raw inputs, each optionally inverted by its own configuration pin.

A word is 8 bits, or 9 bits when the ninth-bit mode is selected. When a word is complete, it moves into a holding register, which is presented on a valid/ready output stream. `out_valid` is the receive-complete flag. A word leaves the holding register on any cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the held word and its ninth bit stay frozen. There is no back-pressure towards the serial side, because the master owns the clock. A word that completes while the previous word is still held is therefore dropped, and an overrun flag is raised. The ninth bit is presented on its own pin, `out_bit9`, beside the byte. A consumer must take the ninth bit in the same cycle that it accepts the byte.

The receiver runs only while the continuous-receive enable is high. Dropping the enable is the only way to clear an overrun, and it also discards any partial word. The single-receive request pin has no effect in this slave role.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, `out_valid`, `stat_overrun` and `irq` are 0.
- R2: With `cfg_en`=1 and no inversion, the block samples `ser_dat` on each falling edge of `ser_clk`. Bit 0 of the word arrives first. After the 8th edge, `out_valid` goes to 1 and `out_data` holds the byte.
- R3: With `cfg_nine`=1, the block receives 9 bits, and the 9th bit appears on `out_bit9`. With `cfg_nine`=0, `out_bit9` is 0.
- R4: With `cfg_clk_inv`=1, the block samples on the rising edges of the raw `ser_clk`.
- R5: With `cfg_dat_inv`=1, each stored bit is the complement of the raw `ser_dat`.
- R6: While `cfg_en`=0, no word is received. Dropping `cfg_en` in the middle of a word discards the bits already taken.
- R7: `cfg_single_req` has no effect on reception.
- R8: A cycle with `out_valid`=1 and `out_ready`=1 clears `out_valid`. While `out_valid`=1 and `out_ready`=0, `out_data` and `out_bit9` do not change.
- R9: If a word completes while `out_valid`=1 and no pop happens in that cycle, `stat_overrun` goes to 1 and the held word is kept. While `stat_overrun`=1, later words are ignored.
- R10: `stat_overrun` stays at 1 while `cfg_en`=1 and is cleared in the cycle after `cfg_en` is 0.
- R11: `stat_framing` is always 0.
- R12: `irq` is 1 exactly when `out_valid`=1 and `cfg_irq_en`=1.
- R13: If a word completes in the same cycle as a pop, the new word is loaded, `out_valid` stays 1 and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Continuous-receive enable; low clears errors |
| cfg_single_req | input | 1 | Single-receive request, ignored |
| cfg_nine | input | 1 | 9-bit word mode |
| cfg_clk_inv | input | 1 | Invert serial clock |
| cfg_dat_inv | input | 1 | Invert serial data |
| cfg_irq_en | input | 1 | Receive interrupt enable |
| ser_clk | input | 1 | Serial clock from master |
| ser_dat | input | 1 | Serial data from master |
| out_valid | output | 1 | Holding register full (receive complete) |
| out_ready | input | 1 | Consumer accepts the held word |
| out_data | output | 8 | Received byte |
| out_bit9 | output | 1 | Ninth received bit |
| stat_overrun | output | 1 | Overrun error |
| stat_framing | output | 1 | Framing error, constant 0 |
| irq | output | 1 | Receive interrupt request |

## Verification
A completing word and a consumer pop can fall in the same system cycle. In that cycle, the holding register must swap the old word for the new one without flagging an overrun. The bench provokes this by counting the synchronizer and edge-detect stages after the last serial falling edge. It then raises `out_ready` for exactly the one cycle in which the word lands. It judges the result by checking three things afterwards: `out_valid` is still high, `out_data` holds the new word, and `stat_overrun` is low. A companion case holds `out_ready` low instead, and must see the old word kept and the overrun raised.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  localparam int unsigned SSRX_BYTE_W  = 8;
  localparam int unsigned SSRX_SYNC_N  = 2;
  function automatic int unsigned ssrx_cnt_w(input int unsigned data_w);
    return $clog2(data_w + 1);
  endfunction
endpackage

// File: rtl/ssrx_sync.sv
module ssrx_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= rst_val;
      else if (i == 0) stage[i] <= d;
      else stage[i] <= stage[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/ssrx_shift.sv
module ssrx_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = ssrx_pkg::ssrx_cnt_w(DATA_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          nine,
  input  logic          ck,
  input  logic          dat,
  output logic          done,
  output logic [DATA_W:0] word
);
  logic             ck_d;
  logic             fall;
  logic             last;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W:0]  shreg;
  logic [DATA_W:0]  nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_d <= 1'b0;
    else ck_d <= ck;
  end

  assign fall = ck_d & ~ck;
  assign last = nine ? (cnt == CNT_W'(DATA_W)) : (cnt == CNT_W'(DATA_W-1));

  always_comb begin
    nxt      = shreg;
    nxt[cnt] = dat;
  end

  assign done = run & fall & last;
  assign word = {nxt[DATA_W] & nine, nxt[DATA_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (!run) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (fall) begin
      if (last) begin
        cnt   <= '0;
        shreg <= '0;
      end else begin
        cnt   <= cnt + 1'b1;
        shreg <= nxt;
      end
    end
  end
endmodule

// File: rtl/ssrx_hold.sv
module ssrx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              done,
  input  logic [DATA_W:0]   word,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              bit9,
  output logic              overrun
);
  logic pop;
  assign pop = valid & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      data    <= '0;
      bit9    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (done) begin
        if (valid && !pop) begin
          overrun <= 1'b1;
        end else begin
          valid <= 1'b1;
          data  <= word[DATA_W-1:0];
          bit9  <= word[DATA_W];
        end
      end else if (pop) begin
        valid <= 1'b0;
      end
      if (!en) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx #(
  parameter int unsigned DATA_W = ssrx_pkg::SSRX_BYTE_W,
  parameter int unsigned SYNC_N = ssrx_pkg::SSRX_SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_single_req,
  input  logic              cfg_nine,
  input  logic              cfg_clk_inv,
  input  logic              cfg_dat_inv,
  input  logic              cfg_irq_en,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_bit9,
  output logic              stat_overrun,
  output logic              stat_framing,
  output logic              irq
);
  logic [1:0]      ser_sync;
  logic            eff_ck;
  logic            eff_dat;
  logic            run;
  logic            done;
  logic [DATA_W:0] word;
  logic            unused_single;

  assign unused_single = cfg_single_req;

  ssrx_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d       ({ser_dat, ser_clk}),
    .rst_val (2'b00),
    .q       (ser_sync)
  );

  assign eff_ck  = ser_sync[0] ^ cfg_clk_inv;
  assign eff_dat = ser_sync[1] ^ cfg_dat_inv;
  assign run     = cfg_en & ~stat_overrun;

  ssrx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .nine (cfg_nine),
    .ck   (eff_ck),
    .dat  (eff_dat),
    .done (done),
    .word (word)
  );

  ssrx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cfg_en),
    .done   (done),
    .word   (word),
    .ready  (out_ready),
    .valid  (out_valid),
    .data   (out_data),
    .bit9   (out_bit9),
    .overrun(stat_overrun)
  );

  assign stat_framing = 1'b0;
  assign irq          = out_valid & cfg_irq_en;
endmodule

// File: rtl/ssrx_chk.sv
module ssrx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              cfg_irq_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_bit9,
  input logic              stat_overrun,
  input logic              irq
);
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_bit9)));

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_overrun && cfg_en) |=> stat_overrun);

  p_ovr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !stat_overrun);

  p_ovr_needs_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_overrun) |-> out_valid);

  p_irq_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !irq);

  p_irq_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> out_valid);
endmodule

bind sync_slave_rx ssrx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_en      (cfg_en),
  .cfg_irq_en  (cfg_irq_en),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_bit9    (out_bit9),
  .stat_overrun(stat_overrun),
  .irq         (irq)
);

// File: tb/sync_slave_rx_test.sv
module sync_slave_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0, cfg_single_req = 1'b0, cfg_nine = 1'b0;
  logic       cfg_clk_inv = 1'b0, cfg_dat_inv = 1'b0, cfg_irq_en = 1'b0;
  logic       ser_clk = 1'b1, ser_dat = 1'b0;
  logic       out_valid, out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_bit9, stat_overrun, stat_framing, irq;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sync_slave_rx uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_single_req(cfg_single_req),
    .cfg_nine(cfg_nine), .cfg_clk_inv(cfg_clk_inv), .cfg_dat_inv(cfg_dat_inv),
    .cfg_irq_en(cfg_irq_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_bit9(out_bit9), .stat_overrun(stat_overrun), .stat_framing(stat_framing),
    .irq(irq)
  );

  function automatic logic [7:0] exp_byte(input logic [8:0] w);
    return w[7:0];
  endfunction

  function automatic logic exp_b9(input logic [8:0] w, input logic nine);
    return nine ? w[8] : 1'b0;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit-level driver: effective clock high, data set, then effective falling edge
  task automatic send_word(input logic [8:0] w, input int n, input bit pulse_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ser_dat = w[i] ^ cfg_dat_inv;
      ser_clk = 1'b1 ^ cfg_clk_inv;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0 ^ cfg_clk_inv;
      if (pulse_last && i == n-1) begin
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
      end else begin
        repeat (4) @(negedge clk);
      end
    end
    @(negedge clk);
    ser_clk = 1'b1 ^ cfg_clk_inv;
    repeat (6) @(negedge clk);
  endtask

  task automatic configure(input logic nine, input logic ci, input logic di, input logic ie);
    @(negedge clk);
    cfg_en      = 1'b0;
    cfg_nine    = nine;
    cfg_clk_inv = ci;
    cfg_dat_inv = di;
    cfg_irq_en  = ie;
    ser_clk     = 1'b1 ^ ci;
    repeat (6) @(negedge clk);
    cfg_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [8:0] w, a, b;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 valid", 16'(out_valid), 16'd0);
    check("R1 overrun", 16'(stat_overrun), 16'd0);
    check("R1 irq", 16'(irq), 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 plain 8-bit word
    configure(1'b0, 1'b0, 1'b0, 1'b1);
    w = 9'h1A5;
    send_word(w, 8, 0);
    check("R2 valid", 16'(out_valid), 16'd1);
    check("R2 data", 16'(out_data), 16'(exp_byte(w)));
    check("R3 bit9 zero in 8-bit", 16'(out_bit9), 16'd0);
    check("R11 framing", 16'(stat_framing), 16'd0);
    check("R12 irq on", 16'(irq), 16'd1);
    pop();
    check("R8 pop clears", 16'(out_valid), 16'd0);
    check("R12 irq off", 16'(irq), 16'd0);

    // R6 disabled: nothing received; R7 single request ignored
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_single_req = 1'b1;
    send_word(9'h03C, 8, 0);
    check("R6 R7 no rx when disabled", 16'(out_valid), 16'd0);
    cfg_single_req = 1'b0;

    // R6 partial word discarded by dropping enable
    configure(1'b0, 1'b0, 1'b0, 1'b0);
    send_word(9'h1FF, 3, 0);
    @(negedge clk); cfg_en = 1'b0;
    repeat (3) @(negedge clk); cfg_en = 1'b1;
    repeat (2) @(negedge clk);
    w = 9'h05A;
    send_word(w, 8, 0);
    check("R6 restart data", 16'(out_data), 16'h5A);
    check("R12 irq masked", 16'(irq), 16'd0);

    // R8 hold while not ready
    repeat (5) @(negedge clk);
    check("R8 still held", 16'({out_valid, out_data}), 16'h15A);

    // R9 overrun: second word with holding full
    a = 9'h0C3;
    b = 9'h011;
    pop();
    send_word(a, 8, 0);
    send_word(b, 8, 0);
    check("R9 overrun set", 16'(stat_overrun), 16'd1);
    check("R9 old kept", 16'(out_data), 16'(exp_byte(a)));
    pop();
    send_word(9'h077, 8, 0);
    check("R9 ignored while overrun", 16'(out_valid), 16'd0);
    check("R10 overrun sticky", 16'(stat_overrun), 16'd1);
    @(negedge clk); cfg_en = 1'b0;
    @(negedge clk);
    check("R10 cleared by enable low", 16'(stat_overrun), 16'd0);
    cfg_en = 1'b1;
    repeat (2) @(negedge clk);

    // R13 completion in the pop cycle
    a = 9'h024;
    b = 9'h0E7;
    send_word(a, 8, 0);
    send_word(b, 8, 1);
    check("R13 valid kept", 16'(out_valid), 16'd1);
    check("R13 new word", 16'(out_data), 16'(exp_byte(b)));
    check("R13 no overrun", 16'(stat_overrun), 16'd0);
    pop();

    // R3 R4 R5 directed 9-bit with both inversions
    configure(1'b1, 1'b1, 1'b1, 1'b1);
    w = 9'h16D;
    send_word(w, 9, 0);
    check("R3 R4 R5 data", 16'(out_data), 16'h6D);
    check("R3 bit9", 16'(out_bit9), 16'd1);
    pop();

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic nine, ci, di, ie;
      nine = 1'($urandom);
      ci   = 1'($urandom);
      di   = 1'($urandom);
      ie   = 1'($urandom);
      w    = 9'($urandom);
      configure(nine, ci, di, ie);
      send_word(w, nine ? 9 : 8, 0);
      check("R2 R4 R5 rand valid", 16'(out_valid), 16'd1);
      check("R2 R4 R5 rand data", 16'(out_data), 16'(exp_byte(w)));
      check("R3 rand bit9", 16'(out_bit9), 16'(exp_b9(w, nine)));
      check("R12 rand irq", 16'(irq), 16'(ie));
      pop();
      check("R8 rand pop", 16'(out_valid), 16'd0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule